// File: doc/BRIEF.md
# Template Search Tracker

This block locates a small square template inside a larger square search window that already sits in local memory. For every candidate placement of the template inside the window it forms the sum of absolute pixel differences, keeps the placement with the lowest sum, and reports that placement in frame coordinates together with the score. From the newly found location and the location supplied for the previous frame it then extrapolates, assuming constant velocity, where the next frame's search window should start, clamped so that the window stays inside the frame.

A controller loads the template and window memories, presents the current window origin and the previous template location, and pulses `start`. The block reads both memories through simple synchronous read ports (data one cycle after the address), scans all candidates, and signals completion with a one-cycle `done`. Results stay on the outputs until the following search completes.

Top module: `sad_trk_top`

## Requirements
- R1: After reset `busy` and `done` are low and `loc_x`, `loc_y`, `min_sad`, `next_org_x`, `next_org_y` are all zero.
- R2: A `start` pulse seen while idle (including the cycle in which `done` is high) latches `org_x`, `org_y`, `prev_x`, `prev_y` and begins a search; `start` while busy is ignored, and later changes of the origin inputs do not affect a running search.
- R3: The score of a candidate at window offset (cx, cy) is the sum over template row r and column c of |T[r*TW+c] - W[(cy+r)*SW+(cx+c)]|, where T is read at address `r*TW+c` and W at address `row*SW+col`, each returning data one cycle after the address; `min_sad` reports the lowest score, up to (2^PIX_W-1)*TW*TW without overflow.
- R4: `loc_x`/`loc_y` equal the latched origin plus the offset of the winning candidate.
- R5: Candidates are visited with cx varying fastest, then cy; when scores are equal the earlier candidate wins.
- R6: `done` is high for exactly one cycle, on the (NC*NC*TW*TW + 2)-th rising edge after the edge that accepted `start`, with NC = SW-TW+1.
- R7: All result outputs hold their values in every cycle except the one in which `done` is high.
- R8: `next_org_x` = clamp(2*`loc_x` - prev_x, 0, FRAME_W-SW), and likewise for y with FRAME_H-SW.
- R9: `busy` is high from the edge that accepts `start` until the edge that raises `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a search (accepted when idle) |
| org_x | input | CW | Search window origin, x, in frame coordinates |
| org_y | input | CW | Search window origin, y |
| prev_x | input | CW | Template location in the previous frame, x |
| prev_y | input | CW | Template location in the previous frame, y |
| tpl_addr | output | TAW | Template memory read address |
| tpl_data | input | PIX_W | Template memory read data (one cycle latency) |
| win_addr | output | WAW | Search window memory read address |
| win_data | input | PIX_W | Search window memory read data (one cycle latency) |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle completion strobe |
| loc_x | output | CW | Best-match location, x |
| loc_y | output | CW | Best-match location, y |
| min_sad | output | SADW | Score of the best match |
| next_org_x | output | CW | Predicted next search origin, x |
| next_org_y | output | CW | Predicted next search origin, y |

## Verification
On every cycle the assertions check that `done` is a single-cycle strobe that closes a busy period, that results never move outside the `done` cycle, that the predicted origin stays within the legal range, that the running best score never increases within a search, and that both memory addresses stay inside their arrays. The actual scores, the tie rule, the latency to `done`, the clamping arithmetic and the rejection of a start while busy depend on image content and timing, so only the bench's scenarios against its own reference search can show them.

// File: rtl/sad_trk_pkg.sv
package sad_trk_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SCAN,
    ST_DRAIN,
    ST_PREDICT
  } trk_state_e;

  // magnitude of the difference of two pixel values
  function automatic int abs_gap(input int a, input int b);
    return (a > b) ? (a - b) : (b - a);
  endfunction

  // linear address of (row, col) in a row-major array of given stride
  function automatic int raster_index(input int row, input int col, input int stride);
    return row * stride + col;
  endfunction

  // constant-velocity extrapolation of one axis, clamped to [0, hi]
  function automatic int extrapolate_axis(input int cur, input int prev, input int hi);
    int p;
    p = 2 * cur - prev;
    if (p < 0) return 0;
    if (p > hi) return hi;
    return p;
  endfunction

endpackage

// File: rtl/sad_trk_scan.sv
module sad_trk_scan
  import sad_trk_pkg::*;
#(
  parameter int TW = 8,
  parameter int SW = 24,
  localparam int NC  = SW - TW + 1,
  localparam int OW  = (NC > 1) ? $clog2(NC) : 1,
  localparam int TIW = (TW > 1) ? $clog2(TW) : 1,
  localparam int TAW = $clog2(TW * TW),
  localparam int WAW = $clog2(SW * SW)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           clr,
  input  logic           run,
  output logic [TAW-1:0] tpl_addr,
  output logic [WAW-1:0] win_addr,
  output logic [OW-1:0]  cand_x,
  output logic [OW-1:0]  cand_y,
  output logic           pix_first,
  output logic           pix_last,
  output logic           scan_end
);

  logic [TIW-1:0] tx, ty;
  logic [OW-1:0]  cx, cy;

  logic tx_end, ty_end, cx_end, cy_end;
  assign tx_end = (tx == TIW'(TW - 1));
  assign ty_end = (ty == TIW'(TW - 1));
  assign cx_end = (cx == OW'(NC - 1));
  assign cy_end = (cy == OW'(NC - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx <= '0;
      ty <= '0;
      cx <= '0;
      cy <= '0;
    end else if (clr) begin
      tx <= '0;
      ty <= '0;
      cx <= '0;
      cy <= '0;
    end else if (run) begin
      if (!tx_end) begin
        tx <= tx + 1'b1;
      end else begin
        tx <= '0;
        if (!ty_end) begin
          ty <= ty + 1'b1;
        end else begin
          ty <= '0;
          if (!cx_end) begin
            cx <= cx + 1'b1;
          end else begin
            cx <= '0;
            cy <= cy_end ? '0 : cy + 1'b1;
          end
        end
      end
    end
  end

  assign tpl_addr  = TAW'(raster_index(int'(ty), int'(tx), TW));
  assign win_addr  = WAW'(raster_index(int'(cy) + int'(ty), int'(cx) + int'(tx), SW));
  assign cand_x    = cx;
  assign cand_y    = cy;
  assign pix_first = (tx == '0) && (ty == '0);
  assign pix_last  = tx_end && ty_end;
  assign scan_end  = tx_end && ty_end && cx_end && cy_end;

endmodule

// File: rtl/sad_trk_accum.sv
module sad_trk_accum
  import sad_trk_pkg::*;
#(
  parameter int PIX_W = 8,
  parameter int SADW  = 14,
  parameter int OW    = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             in_valid,
  input  logic             in_first,
  input  logic             in_last,
  input  logic [OW-1:0]    in_cx,
  input  logic [OW-1:0]    in_cy,
  input  logic [PIX_W-1:0] tpl_pix,
  input  logic [PIX_W-1:0] win_pix,
  output logic             cand_evt,
  output logic             have_best,
  output logic [SADW-1:0]  best_sad,
  output logic [OW-1:0]    best_cx,
  output logic [OW-1:0]    best_cy
);

  logic            s1_valid, s1_first, s1_last;
  logic [OW-1:0]   s1_cx, s1_cy;
  logic [SADW-1:0] acc;
  logic [SADW-1:0] gap;
  logic [SADW-1:0] cand_sad;
  logic            best_upd;

  assign gap      = SADW'(abs_gap(int'(tpl_pix), int'(win_pix)));
  assign cand_sad = (s1_first ? '0 : acc) + gap;
  assign cand_evt = s1_valid && s1_last;
  // strict less-than keeps the earliest candidate on a tie
  assign best_upd = cand_evt && (!have_best || (cand_sad < best_sad));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid  <= 1'b0;
      s1_first  <= 1'b0;
      s1_last   <= 1'b0;
      s1_cx     <= '0;
      s1_cy     <= '0;
      acc       <= '0;
      have_best <= 1'b0;
      best_sad  <= '0;
      best_cx   <= '0;
      best_cy   <= '0;
    end else if (clr) begin
      s1_valid  <= 1'b0;
      have_best <= 1'b0;
    end else begin
      s1_valid <= in_valid;
      s1_first <= in_first;
      s1_last  <= in_last;
      s1_cx    <= in_cx;
      s1_cy    <= in_cy;
      if (s1_valid) acc <= cand_sad;
      if (best_upd) begin
        best_sad <= cand_sad;
        best_cx  <= s1_cx;
        best_cy  <= s1_cy;
      end
      if (cand_evt) have_best <= 1'b1;
    end
  end

endmodule

// File: rtl/sad_trk_predict.sv
module sad_trk_predict
  import sad_trk_pkg::*;
#(
  parameter int CW      = 10,
  parameter int SW      = 24,
  parameter int FRAME_W = 640,
  parameter int FRAME_H = 480
) (
  input  logic [CW-1:0] cur_x,
  input  logic [CW-1:0] cur_y,
  input  logic [CW-1:0] prev_x,
  input  logic [CW-1:0] prev_y,
  output logic [CW-1:0] pred_x,
  output logic [CW-1:0] pred_y
);

  assign pred_x = CW'(extrapolate_axis(int'(cur_x), int'(prev_x), FRAME_W - SW));
  assign pred_y = CW'(extrapolate_axis(int'(cur_y), int'(prev_y), FRAME_H - SW));

endmodule

// File: rtl/sad_trk_top.sv
module sad_trk_top
  import sad_trk_pkg::*;
#(
  parameter int PIX_W   = 8,
  parameter int TW      = 8,
  parameter int SW      = 24,
  parameter int FRAME_W = 640,
  parameter int FRAME_H = 480,
  localparam int NC   = SW - TW + 1,
  localparam int OW   = (NC > 1) ? $clog2(NC) : 1,
  localparam int CW   = $clog2((FRAME_W > FRAME_H) ? FRAME_W : FRAME_H),
  localparam int TAW  = $clog2(TW * TW),
  localparam int WAW  = $clog2(SW * SW),
  localparam int SADW = $clog2((2 ** PIX_W - 1) * TW * TW + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CW-1:0]    org_x,
  input  logic [CW-1:0]    org_y,
  input  logic [CW-1:0]    prev_x,
  input  logic [CW-1:0]    prev_y,
  output logic [TAW-1:0]   tpl_addr,
  input  logic [PIX_W-1:0] tpl_data,
  output logic [WAW-1:0]   win_addr,
  input  logic [PIX_W-1:0] win_data,
  output logic             busy,
  output logic             done,
  output logic [CW-1:0]    loc_x,
  output logic [CW-1:0]    loc_y,
  output logic [SADW-1:0]  min_sad,
  output logic [CW-1:0]    next_org_x,
  output logic [CW-1:0]    next_org_y
);

  trk_state_e state;

  logic [CW-1:0] org_x_q, org_y_q, prev_x_q, prev_y_q;

  // named internal events, also seen by the checker
  logic            start_acc;
  logic            scan_run;
  logic            scan_end;
  logic            pix_first, pix_last;
  logic [OW-1:0]   cand_x, cand_y;
  logic            cand_evt;
  logic            have_best;
  logic [SADW-1:0] run_best;
  logic [OW-1:0]   best_cx, best_cy;
  logic [CW-1:0]   cur_x, cur_y;
  logic [CW-1:0]   pred_x, pred_y;

  assign start_acc = start && (state == ST_IDLE);
  assign scan_run  = (state == ST_SCAN);
  assign busy      = (state != ST_IDLE);

  sad_trk_scan #(
    .TW(TW),
    .SW(SW)
  ) u_scan (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (start_acc),
    .run      (scan_run),
    .tpl_addr (tpl_addr),
    .win_addr (win_addr),
    .cand_x   (cand_x),
    .cand_y   (cand_y),
    .pix_first(pix_first),
    .pix_last (pix_last),
    .scan_end (scan_end)
  );

  sad_trk_accum #(
    .PIX_W(PIX_W),
    .SADW (SADW),
    .OW   (OW)
  ) u_accum (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (start_acc),
    .in_valid (scan_run),
    .in_first (pix_first),
    .in_last  (pix_last),
    .in_cx    (cand_x),
    .in_cy    (cand_y),
    .tpl_pix  (tpl_data),
    .win_pix  (win_data),
    .cand_evt (cand_evt),
    .have_best(have_best),
    .best_sad (run_best),
    .best_cx  (best_cx),
    .best_cy  (best_cy)
  );

  assign cur_x = org_x_q + CW'(best_cx);
  assign cur_y = org_y_q + CW'(best_cy);

  sad_trk_predict #(
    .CW     (CW),
    .SW     (SW),
    .FRAME_W(FRAME_W),
    .FRAME_H(FRAME_H)
  ) u_predict (
    .cur_x (cur_x),
    .cur_y (cur_y),
    .prev_x(prev_x_q),
    .prev_y(prev_y_q),
    .pred_x(pred_x),
    .pred_y(pred_y)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      org_x_q    <= '0;
      org_y_q    <= '0;
      prev_x_q   <= '0;
      prev_y_q   <= '0;
      done       <= 1'b0;
      loc_x      <= '0;
      loc_y      <= '0;
      min_sad    <= '0;
      next_org_x <= '0;
      next_org_y <= '0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (start) begin
            org_x_q  <= org_x;
            org_y_q  <= org_y;
            prev_x_q <= prev_x;
            prev_y_q <= prev_y;
            state    <= ST_SCAN;
          end
        end
        ST_SCAN: begin
          if (scan_end) state <= ST_DRAIN;
        end
        ST_DRAIN: begin
          state <= ST_PREDICT;
        end
        ST_PREDICT: begin
          loc_x      <= cur_x;
          loc_y      <= cur_y;
          min_sad    <= run_best;
          next_org_x <= pred_x;
          next_org_y <= pred_y;
          done       <= 1'b1;
          state      <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/sad_trk_chk.sv
module sad_trk_chk #(
  parameter int TW      = 8,
  parameter int SW      = 24,
  parameter int FRAME_W = 640,
  parameter int FRAME_H = 480,
  parameter int CW      = 10,
  parameter int TAW     = 6,
  parameter int WAW     = 10,
  parameter int SADW    = 14
) (
  input logic            clk,
  input logic            rst_n,
  input logic            start,
  input logic            busy,
  input logic            done,
  input logic            scan_run,
  input logic            cand_evt,
  input logic            have_best,
  input logic [SADW-1:0] run_best,
  input logic [TAW-1:0]  tpl_addr,
  input logic [WAW-1:0]  win_addr,
  input logic [CW-1:0]   loc_x,
  input logic [CW-1:0]   loc_y,
  input logic [SADW-1:0] min_sad,
  input logic [CW-1:0]   next_org_x,
  input logic [CW-1:0]   next_org_y
);

  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R9
  done_ends_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));

  // R2
  start_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (busy && !done));

  // R7
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable({loc_x, loc_y, min_sad, next_org_x, next_org_y}));

  // R8
  next_org_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(next_org_x) <= FRAME_W - SW) && (int'(next_org_y) <= FRAME_H - SW));

  // R5
  best_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (have_best && $past(have_best)) |-> (run_best <= $past(run_best)));

  // R3
  addr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    scan_run |-> ((int'(win_addr) < SW * SW) && (int'(tpl_addr) < TW * TW)));

  // R3
  cand_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cand_evt |-> busy);

endmodule

bind sad_trk_top sad_trk_chk #(
  .TW     (TW),
  .SW     (SW),
  .FRAME_W(FRAME_W),
  .FRAME_H(FRAME_H),
  .CW     (CW),
  .TAW    (TAW),
  .WAW    (WAW),
  .SADW   (SADW)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .busy      (busy),
  .done      (done),
  .scan_run  (scan_run),
  .cand_evt  (cand_evt),
  .have_best (have_best),
  .run_best  (run_best),
  .tpl_addr  (tpl_addr),
  .win_addr  (win_addr),
  .loc_x     (loc_x),
  .loc_y     (loc_y),
  .min_sad   (min_sad),
  .next_org_x(next_org_x),
  .next_org_y(next_org_y)
);

// File: tb/sad_trk_top_test.sv
module sad_trk_top_test;

  localparam int CLK_PERIOD = 10;
  localparam int PIX_W = 8;
  localparam int TW    = 4;
  localparam int SW    = 10;
  localparam int FW    = 64;
  localparam int FH    = 48;
  localparam int NC    = SW - TW + 1;
  localparam int NRUN  = NC * NC * TW * TW;
  localparam int CW    = 6;
  localparam int TAW   = 4;
  localparam int WAW   = 7;
  localparam int SADW  = 12;
  localparam int WATCHDOG = 150000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [CW-1:0] org_x = '0, org_y = '0, prev_x = '0, prev_y = '0;
  logic [TAW-1:0] tpl_addr;
  logic [WAW-1:0] win_addr;
  logic [PIX_W-1:0] tpl_data, win_data;
  logic busy, done;
  logic [CW-1:0] loc_x, loc_y, next_org_x, next_org_y;
  logic [SADW-1:0] min_sad;

  logic [PIX_W-1:0] tpl_mem [TW*TW];
  logic [PIX_W-1:0] win_mem [SW*SW];

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    tpl_data <= tpl_mem[tpl_addr];
    win_data <= win_mem[win_addr];
  end

  sad_trk_top #(
    .PIX_W(PIX_W), .TW(TW), .SW(SW), .FRAME_W(FW), .FRAME_H(FH)
  ) uut (
    .clk(clk), .rst_n(rst_n), .start(start),
    .org_x(org_x), .org_y(org_y), .prev_x(prev_x), .prev_y(prev_y),
    .tpl_addr(tpl_addr), .tpl_data(tpl_data),
    .win_addr(win_addr), .win_data(win_data),
    .busy(busy), .done(done), .loc_x(loc_x), .loc_y(loc_y),
    .min_sad(min_sad), .next_org_x(next_org_x), .next_org_y(next_org_y)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  function automatic void check(bit ok, string tag, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endfunction

  // ---------------- reference model ----------------
  bit m_busy = 1'b0, m_done = 1'b0;
  int m_cnt = 0;
  int m_lx = 0, m_ly = 0, m_sad = 0, m_nx = 0, m_ny = 0;
  int p_lx, p_ly, p_sad, p_nx, p_ny;

  function automatic int clampv(int v, int hi);
    if (v < 0) return 0;
    if (v > hi) return hi;
    return v;
  endfunction

  function automatic void model_search(int ox, int oy, int px, int py);
    int best = -1;
    int bx = 0, by = 0;
    for (int cy = 0; cy < NC; cy++) begin
      for (int cx = 0; cx < NC; cx++) begin
        int s = 0;
        for (int r = 0; r < TW; r++) begin
          for (int c = 0; c < TW; c++) begin
            int d = int'(tpl_mem[r*TW+c]) - int'(win_mem[(cy+r)*SW + cx + c]);
            s += (d < 0) ? -d : d;
          end
        end
        if (best < 0 || s < best) begin
          best = s; bx = cx; by = cy;
        end
      end
    end
    p_lx  = ox + bx;
    p_ly  = oy + by;
    p_sad = best;
    p_nx  = clampv(2*p_lx - px, FW - SW);
    p_ny  = clampv(2*p_ly - py, FH - SW);
  endfunction

  always @(negedge clk) begin
    if (!finished) begin
      check(busy === m_busy, "R9 busy", longint'(busy), longint'(m_busy));
      check(done === m_done, "R6 done", longint'(done), longint'(m_done));
      check(int'(loc_x) == m_lx && int'(loc_y) == m_ly, "R4 loc",
            longint'(loc_x)*1000 + loc_y, longint'(m_lx)*1000 + m_ly);
      check(int'(min_sad) == m_sad, "R3 min_sad", longint'(min_sad), m_sad);
      check(int'(next_org_x) == m_nx && int'(next_org_y) == m_ny, "R8 next_org",
            longint'(next_org_x)*1000 + next_org_y, longint'(m_nx)*1000 + m_ny);
    end
    if (!rst_n) begin
      m_busy = 0; m_done = 0; m_cnt = 0;
      m_lx = 0; m_ly = 0; m_sad = 0; m_nx = 0; m_ny = 0;
    end else begin
      m_done = 0;
      if (!m_busy) begin
        if (start) begin
          model_search(int'(org_x), int'(org_y), int'(prev_x), int'(prev_y));
          m_busy = 1;
          m_cnt = NRUN + 2;
        end
      end else begin
        m_cnt--;
        if (m_cnt == 0) begin
          m_busy = 0; m_done = 1;
          m_lx = p_lx; m_ly = p_ly; m_sad = p_sad; m_nx = p_nx; m_ny = p_ny;
        end
      end
    end
  end

  // ---------------- stimulus ----------------
  // called at posedge+1; returns at posedge+1 of the done cycle
  task automatic launch(int ox, int oy, int px, int py, bit poke,
                        int elx, int ely, int esad, int enx, int eny, string tag);
    org_x = CW'(ox); org_y = CW'(oy); prev_x = CW'(px); prev_y = CW'(py);
    start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
    for (int k = 0; k < NRUN + 2; k++) begin
      @(posedge clk); #1;
      start = poke && (k == 99);
      if (poke && k == 99) begin
        org_x = CW'(1); org_y = CW'(1); prev_x = CW'(2); prev_y = CW'(2);
      end
    end
    check(done === 1'b1, {"R6 done timing ", tag}, longint'(done), 1);
    check(int'(loc_x) == elx, {"R4 loc_x ", tag}, loc_x, elx);
    check(int'(loc_y) == ely, {"R4 loc_y ", tag}, loc_y, ely);
    check(int'(min_sad) == esad, {"R3 min_sad ", tag}, min_sad, esad);
    check(int'(next_org_x) == enx, {"R8 next_org_x ", tag}, next_org_x, enx);
    check(int'(next_org_y) == eny, {"R8 next_org_y ", tag}, next_org_y, eny);
  endtask

  task automatic fill_pattern_with_plant(int px0, int py0);
    for (int i = 0; i < SW*SW; i++) win_mem[i] = PIX_W'((i*73 + 17) % 251);
    for (int r = 0; r < TW; r++)
      for (int c = 0; c < TW; c++)
        tpl_mem[r*TW+c] = win_mem[(py0+r)*SW + px0 + c];
  endtask

  task automatic fill_flat(int wv, int tv);
    for (int i = 0; i < SW*SW; i++) win_mem[i] = PIX_W'(wv);
    for (int i = 0; i < TW*TW; i++) tpl_mem[i] = PIX_W'(tv);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++; errors++;
      $display("FAIL R6 watchdog: actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    fill_pattern_with_plant(3, 5);
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(busy === 1'b0 && done === 1'b0, "R1 busy/done after reset", longint'(busy), 0);
    check(loc_x == 0 && loc_y == 0 && min_sad == 0 && next_org_x == 0 && next_org_y == 0,
          "R1 results after reset", longint'(min_sad), 0);
    @(posedge clk); #1;

    // exact match at offset (3,5); prediction inside frame (R4, R8)
    launch(20, 10, 18, 12, 1'b0, 23, 15, 0, 28, 18, "plant");
    // R2: chained start in the done cycle, plus an ignored start mid-run
    launch(20, 10, 22, 14, 1'b1, 23, 15, 0, 24, 16, "R2 poke");

    // R7: results held while idle
    repeat (5) @(posedge clk); #1;
    check(int'(loc_x) == 23 && int'(loc_y) == 15 && int'(next_org_x) == 24,
          "R7 hold while idle", loc_x, 23);

    // R5: every candidate ties, earliest (offset 0,0) wins
    fill_flat(9, 9);
    launch(5, 5, 5, 5, 1'b0, 5, 5, 0, 5, 5, "R5 tie");

    // R3: largest possible score, R8 low clamp
    fill_flat(0, 255);
    launch(0, 0, 40, 40, 1'b0, 0, 0, 255*TW*TW, 0, 0, "R3 max");

    // R5 last candidate, R8 high clamp
    fill_flat(0, 255);
    for (int r = 0; r < TW; r++)
      for (int c = 0; c < TW; c++)
        win_mem[(NC-1+r)*SW + NC-1 + c] = 8'd255;
    launch(54, 38, 0, 0, 1'b0, 60, 44, 0, FW - SW, FH - SW, "R5 last");

    repeat (3) @(posedge clk);
    @(negedge clk);
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule